// File: doc/BRIEF.md
# Staged Two-Domain Reset Sequencer

This block generates two active-low resets for an accelerator subsystem. One covers the subsystem fabric: local memories, registers and the host-side bus target. The other covers the embedded processing core inside it. After a global reset or a re-assert request, both resets are held low together for a guaranteed minimum number of clock cycles.

Release then happens in two stages. Each stage is triggered by a host strobe. The subsystem reset goes high first, so the host can reach local storage and registers to load code and set up address translation. During this window the core stays in reset. Once the host has finished its setup, it issues a second strobe, and the core reset goes high. The core then begins fetching from address zero, and a one-cycle start pulse marks that moment.

A 3-bit status word reports the current stage and a sticky flag. The flag records a core-release strobe that arrived before the subsystem was out of reset.

Top module: `stage_rst_seq`

## Requirements
- R1: After the global reset is released, or after a re-assert request, both reset outputs stay low for at least MIN_CYC (default 16) clock cycles. The subsystem reset cannot rise until the 16th rising edge after that point has passed.
- R2: The subsystem reset rises only in response to a subsystem-release strobe. If no strobe arrives, both resets stay low indefinitely, even after the minimum time has expired.
- R3: A subsystem-release strobe that arrives before the minimum time has expired is remembered. The subsystem reset then rises on the first rising edge after the minimum has elapsed, with no further strobe needed. A strobe that arrives after the minimum has elapsed raises the subsystem reset at the next rising edge.
- R4: The core reset is never high while the subsystem reset is low. While only the subsystem is released, the core reset stays low until the core-release strobe arrives.
- R5: A core-release strobe sampled while the subsystem is released (and the core is not) raises the core reset at the next rising edge.
- R6: The core-start output is high for exactly the one cycle in which the core reset first reads high after its release.
- R7: A core-release strobe sampled while the subsystem is still in reset has no effect on either reset output. It sets status bit 2, which stays set through later releases and re-asserts and is cleared only by the global reset.
- R8: A re-assert request drives both reset outputs low at the next rising edge and restarts the minimum-time count from zero. It also discards any remembered subsystem-release strobe. Any release strobe sampled in the same cycle as a re-assert request is ignored and does not set status bit 2.
- R9: Status bits [1:0] encode the stage: 00 = both in reset, 01 = subsystem released, 10 = core released. The value 11 never appears. The global reset state is 000 for the status word, with both resets low and core-start low.
- R10: Strobes that do not apply to the current stage have no effect. This covers a subsystem-release strobe once the subsystem is released, and a core-release strobe once the core is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Global reset, active low, asynchronous assert |
| sys_rel_i | input | 1 | Host strobe: release the subsystem reset |
| core_rel_i | input | 1 | Host strobe: release the core reset |
| reassert_i | input | 1 | Request to drive both resets low and restart the sequence |
| sub_rst_n_o | output | 1 | Subsystem reset, active low, flop driven |
| core_rst_n_o | output | 1 | Core reset, active low, flop driven |
| core_start_o | output | 1 | One-cycle pulse when the core leaves reset |
| status_o | output | 3 | [1:0] stage code, [2] sticky early-core-release flag |

## Verification
The hardest situations to reach involve the pending release strobe. One is a strobe that arrives early and must survive the rest of the hold window. The other is a strobe that must be thrown away when a re-assert request lands before the window ends. The directed tests set both up by counting falling edges from the exact edge where the count restarts. A strobe is placed in the first cycle of the window, and the bench checks the outputs one cycle before and one cycle after the expected release edge. A separate sequence fires a re-assert request after an early strobe, then waits well past the window to confirm that the subsystem reset stays low.

// File: rtl/stage_rst_pkg.sv
package stage_rst_pkg;

  typedef enum logic [1:0] {
    ST_ALL  = 2'b00,
    ST_SUB  = 2'b01,
    ST_CORE = 2'b10
  } stage_e;

  localparam int STAT_W = 3;

  // True once the hold counter has reached the configured minimum.
  function automatic logic min_reached(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt >= lim);
  endfunction

  // Status word: sticky flag above the stage code.
  function automatic logic [STAT_W-1:0] pack_status(input stage_e st, input logic err);
    return {err, st};
  endfunction

  // Reset levels implied by a stage.
  function automatic logic sub_level(input stage_e st);
    return (st != ST_ALL);
  endfunction

  function automatic logic core_level(input stage_e st);
    return (st == ST_CORE);
  endfunction

endpackage

// File: rtl/stage_hold_timer.sv
module stage_hold_timer #(
  parameter int MIN_CYC = 16,
  localparam int CNT_W  = $clog2(MIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  import stage_rst_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_CYC);

  logic [CNT_W-1:0] cnt_q;

  // Saturating count of cycles spent in the all-reset stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = min_reached(32'(cnt_q), 32'(MIN_CYC));

endmodule

// File: rtl/stage_ctrl_fsm.sv
module stage_ctrl_fsm (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   min_done_i,
  input  logic                   sys_rel_i,
  input  logic                   core_rel_i,
  input  logic                   reassert_i,
  output stage_rst_pkg::stage_e  state_o,
  output stage_rst_pkg::stage_e  nxt_o,
  output logic                   err_o,
  output logic                   sub_rel_ev_o,
  output logic                   core_rel_ev_o,
  output logic                   early_core_ev_o
);
  import stage_rst_pkg::*;

  stage_e state_q, state_d;
  logic   pend_q, pend_d;
  logic   err_q, err_d;
  logic   in_all, in_sub;

  assign in_all = (state_q == ST_ALL);
  assign in_sub = (state_q == ST_SUB);

  // Named events; a re-assert request masks every release.
  assign sub_rel_ev_o    = !reassert_i && in_all && min_done_i && (sys_rel_i || pend_q);
  assign core_rel_ev_o   = !reassert_i && in_sub && core_rel_i;
  assign early_core_ev_o = !reassert_i && in_all && core_rel_i;

  always_comb begin
    state_d = state_q;
    if (reassert_i) begin
      state_d = ST_ALL;
    end else if (sub_rel_ev_o) begin
      state_d = ST_SUB;
    end else if (core_rel_ev_o) begin
      state_d = ST_CORE;
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (reassert_i || sub_rel_ev_o) begin
      pend_d = 1'b0;
    end else if (in_all && sys_rel_i && !min_done_i) begin
      pend_d = 1'b1;
    end
  end

  assign err_d = err_q | early_core_ev_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ALL;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign nxt_o   = state_d;
  assign err_o   = err_q;

endmodule

// File: rtl/stage_out_regs.sv
module stage_out_regs (
  input  logic                  clk,
  input  logic                  rst_n,
  input  stage_rst_pkg::stage_e nxt_i,
  input  logic                  core_rel_ev_i,
  output logic                  sub_rst_n_o,
  output logic                  core_rst_n_o,
  output logic                  start_o
);
  import stage_rst_pkg::*;

  // Reset pins come straight off these flops: no decode after the register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_rst_n_o  <= 1'b0;
      core_rst_n_o <= 1'b0;
      start_o      <= 1'b0;
    end else begin
      sub_rst_n_o  <= sub_level(nxt_i);
      core_rst_n_o <= core_level(nxt_i);
      start_o      <= core_rel_ev_i;
    end
  end

endmodule

// File: rtl/stage_rst_seq.sv
module stage_rst_seq #(
  parameter int MIN_CYC = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rel_i,
  input  logic       core_rel_i,
  input  logic       reassert_i,
  output logic       sub_rst_n_o,
  output logic       core_rst_n_o,
  output logic       core_start_o,
  output logic [2:0] status_o
);
  import stage_rst_pkg::*;

  stage_e state, nxt;
  logic   min_done;
  logic   err;
  logic   sub_rel_ev;
  logic   core_rel_ev;
  logic   early_core_ev;
  logic   hold_run;

  assign hold_run = (state == ST_ALL);

  stage_hold_timer #(.MIN_CYC(MIN_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (por_n),
    .clr_i  (reassert_i),
    .run_i  (hold_run),
    .done_o (min_done)
  );

  stage_ctrl_fsm u_fsm (
    .clk             (clk),
    .rst_n           (por_n),
    .min_done_i      (min_done),
    .sys_rel_i       (sys_rel_i),
    .core_rel_i      (core_rel_i),
    .reassert_i      (reassert_i),
    .state_o         (state),
    .nxt_o           (nxt),
    .err_o           (err),
    .sub_rel_ev_o    (sub_rel_ev),
    .core_rel_ev_o   (core_rel_ev),
    .early_core_ev_o (early_core_ev)
  );

  stage_out_regs u_out (
    .clk           (clk),
    .rst_n         (por_n),
    .nxt_i         (nxt),
    .core_rel_ev_i (core_rel_ev),
    .sub_rst_n_o   (sub_rst_n_o),
    .core_rst_n_o  (core_rst_n_o),
    .start_o       (core_start_o)
  );

  assign status_o = pack_status(state, err);

endmodule

// File: rtl/stage_rst_seq_chk.sv
module stage_rst_seq_chk #(
  parameter int MIN_CYC = 16
) (
  input logic       clk,
  input logic       por_n,
  input logic       core_rel_i,
  input logic       reassert_i,
  input logic       sub_rst_n_o,
  input logic       core_rst_n_o,
  input logic       core_start_o,
  input logic [2:0] status_o,
  input logic       sub_rel_ev,
  input logic       core_rel_ev,
  input logic       early_core_ev
);

  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_cnt <= '0;
    end else if (sub_rst_n_o) begin
      low_cnt <= '0;
    end else if (low_cnt != 16'hFFFF) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // R1
  min_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sub_rst_n_o) |-> (low_cnt >= 16'(MIN_CYC)));

  // R3
  sub_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    sub_rel_ev |=> (sub_rst_n_o && !core_rst_n_o));

  // R4
  core_order_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_rst_n_o |-> sub_rst_n_o);

  // R5
  core_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_rel_ev |=> (core_rst_n_o && core_start_o));

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_start_o |=> !core_start_o);

  // R6
  start_align_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_start_o |-> core_rst_n_o);

  // R7
  early_core_chk: assert property (@(posedge clk) disable iff (!por_n)
    early_core_ev |=> (status_o[2] && !core_rst_n_o));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    status_o[2] |=> status_o[2]);

  // R7
  early_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    (core_rel_i && !sub_rst_n_o && !reassert_i) |=> !core_rst_n_o);

  // R8
  reassert_chk: assert property (@(posedge clk) disable iff (!por_n)
    reassert_i |=> (!sub_rst_n_o && !core_rst_n_o && !core_start_o));

  // R9
  stage_code_chk: assert property (@(posedge clk) disable iff (!por_n)
    (status_o[1:0] != 2'b11) && ((status_o[1:0] == 2'b00) == !sub_rst_n_o)
    && ((status_o[1:0] == 2'b10) == core_rst_n_o));

endmodule

bind stage_rst_seq stage_rst_seq_chk #(.MIN_CYC(MIN_CYC)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .core_rel_i    (core_rel_i),
  .reassert_i    (reassert_i),
  .sub_rst_n_o   (sub_rst_n_o),
  .core_rst_n_o  (core_rst_n_o),
  .core_start_o  (core_start_o),
  .status_o      (status_o),
  .sub_rel_ev    (sub_rel_ev),
  .core_rel_ev   (core_rel_ev),
  .early_core_ev (early_core_ev)
);

// File: tb/tb_stage_rst_seq.sv
module tb_stage_rst_seq;

  localparam int MIN = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sys_rel = 1'b0;
  logic core_rel = 1'b0;
  logic reassert = 1'b0;
  logic sub_n, core_n, start;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  stage_rst_seq #(.MIN_CYC(MIN)) dut (
    .clk          (clk),
    .por_n        (por_n),
    .sys_rel_i    (sys_rel),
    .core_rel_i   (core_rel),
    .reassert_i   (reassert),
    .sub_rst_n_o  (sub_n),
    .core_rst_n_o (core_n),
    .core_start_o (start),
    .status_o     (status)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sys;
    sys_rel = 1'b1; @(negedge clk); sys_rel = 1'b0;
  endtask

  task automatic pulse_core;
    core_rel = 1'b1; @(negedge clk); core_rel = 1'b0;
  endtask

  task automatic pulse_reassert;
    reassert = 1'b1; @(negedge clk); reassert = 1'b0;
  endtask

  // R9: global reset state
  task automatic apply_por;
    por_n = 1'b0;
    wait_neg(3);
    chk("R9", "reset sub", 32'(sub_n), 0);
    chk("R9", "reset core", 32'(core_n), 0);
    chk("R9", "reset start", 32'(start), 0);
    chk("R9", "reset status", 32'(status), 0);
    por_n = 1'b1;
  endtask

  // R1 R3: early strobe held until the minimum expires
  task automatic t_early_strobe;
    apply_por();
    pulse_sys();
    wait_neg(MIN - 1);
    chk("R1", "sub low at minimum edge", 32'(sub_n), 0);
    chk("R1", "stage still 00", 32'(status[1:0]), 0);
    wait_neg(1);
    chk("R3", "sub released by pending strobe", 32'(sub_n), 1);
    chk("R9", "stage 01", 32'(status[1:0]), 1);
    chk("R4", "core held", 32'(core_n), 0);
  endtask

  // R2 R3: no strobe means no release; a late strobe acts at once
  task automatic t_late_strobe;
    apply_por();
    wait_neg(MIN + 8);
    chk("R2", "sub low without strobe", 32'(sub_n), 0);
    pulse_sys();
    chk("R3", "sub released by late strobe", 32'(sub_n), 1);
    chk("R4", "core still low", 32'(core_n), 0);
  endtask

  // R4 R5 R6 R10: core release and ignored strobes
  task automatic t_core_release;
    wait_neg(5);
    chk("R4", "core low before strobe", 32'(core_n), 0);
    pulse_sys();
    chk("R10", "sys strobe in 01 ignored", 32'(status[1:0]), 1);
    chk("R10", "core unchanged", 32'(core_n), 0);
    pulse_core();
    chk("R5", "core released", 32'(core_n), 1);
    chk("R6", "start pulse high", 32'(start), 1);
    chk("R9", "stage 10", 32'(status[1:0]), 2);
    wait_neg(1);
    chk("R6", "start pulse ends", 32'(start), 0);
    sys_rel = 1'b1; core_rel = 1'b1; @(negedge clk); sys_rel = 1'b0; core_rel = 1'b0;
    chk("R10", "stage stays 10", 32'(status[1:0]), 2);
    chk("R10", "no second start", 32'(start), 0);
    chk("R10", "sub still high", 32'(sub_n), 1);
  endtask

  // R8: re-assert from core stage restarts the full hold
  task automatic t_reassert;
    pulse_reassert();
    chk("R8", "sub low after reassert", 32'(sub_n), 0);
    chk("R8", "core low after reassert", 32'(core_n), 0);
    chk("R8", "stage 00", 32'(status[1:0]), 0);
    pulse_sys();
    wait_neg(MIN - 1);
    chk("R8", "hold restarted from zero", 32'(sub_n), 0);
    wait_neg(1);
    chk("R8", "release after restarted hold", 32'(sub_n), 1);
    // re-assert wins over strobes in the same cycle
    reassert = 1'b1; sys_rel = 1'b1; core_rel = 1'b1;
    @(negedge clk);
    reassert = 1'b0; sys_rel = 1'b0; core_rel = 1'b0;
    chk("R8", "core strobe with reassert", 32'(core_n), 0);
    chk("R8", "no flag from masked strobe", 32'(status[2]), 0);
    wait_neg(MIN + 8);
    chk("R8", "masked sys strobe not kept", 32'(sub_n), 0);
  endtask

  // R8: pending strobe discarded by re-assert
  task automatic t_pending_clear;
    apply_por();
    wait_neg(2);
    pulse_sys();
    wait_neg(3);
    pulse_reassert();
    wait_neg(MIN + 8);
    chk("R8", "pending strobe discarded", 32'(sub_n), 0);
    pulse_sys();
    chk("R8", "fresh strobe releases", 32'(sub_n), 1);
  endtask

  // R7: early core strobe sets sticky flag only
  task automatic t_early_core;
    apply_por();
    wait_neg(2);
    pulse_core();
    chk("R7", "flag set", 32'(status[2]), 1);
    chk("R7", "core stays low", 32'(core_n), 0);
    chk("R7", "sub stays low", 32'(sub_n), 0);
    wait_neg(MIN + 2);
    pulse_sys();
    chk("R7", "flag kept after sub release", 32'(status[2]), 1);
    chk("R7", "core low after sub release", 32'(core_n), 0);
    pulse_core();
    chk("R7", "core released normally", 32'(core_n), 1);
    pulse_reassert();
    chk("R7", "flag survives reassert", 32'(status[2]), 1);
    apply_por();
    chk("R7", "flag cleared by global reset", 32'(status[2]), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_early_strobe();
    t_late_strobe();
    t_core_release();
    t_reassert();
    t_pending_clear();
    t_early_core();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule